// File: doc/BRIEF.md
# Lockable Software Watchdog with Timed Reset Request

This block is a watchdog that watches for software that has stopped running properly. It starts disabled. Software arms it by writing a fixed pair of key bytes, one after the other, to a write-only restart register. The register sits on a simple write port made of a select strobe, a small address and an 8-bit data bus. Once armed, a 14-bit counter advances on every clock. Software must write the same key pair again before the counter wraps, and that pair returns the counter to zero.

If the counter wraps, the block raises a reset-request output for a fixed number of clocks. The arming and the count are dropped at that moment, so the watchdog comes back disabled, just as it does after a hardware reset. Software has no way to disarm it. Only the asynchronous reset, the synchronous clear input or an expiry returns it to the disabled state. The `armed_o` output reports whether the watchdog is armed.

Top module: `wdog_once`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `armed_o` is 0, `rst_req_o` is 0 and no first key byte is pending.
- R2: A write with `wr_en`=1 and `wr_addr`=RESTART_ADDR (default 4'h6) carrying 8'h1E, followed by the very next write to that address carrying 8'hE1, sets `armed_o` to 1 from the clock edge that samples the 8'hE1 write.
- R3: Any write to RESTART_ADDR between the two key bytes cancels the pending first byte. This includes a repeated 8'h1E. A lone 8'hE1, or the bytes in the wrong order, does not arm the watchdog.
- R4: Writes to addresses other than RESTART_ADDR are ignored by the key tracker. They do not cancel a pending 8'h1E, and they never count as either key byte.
- R5: Once armed, no write of any value to any address clears `armed_o`.
- R6: While armed, the 14-bit counter advances once per clock. `rst_req_o` rises on the 16384th clock edge after the edge that armed the watchdog.
- R7: Writing the key pair again while armed zeroes the counter. `rst_req_o` then rises 16384 edges after the edge that sampled the 8'hE1 write, not earlier.
- R8: `rst_req_o` stays high for exactly 98 clock cycles. `armed_o` drops to 0 on the same edge that raises `rst_req_o` and stays 0 afterwards.
- R9: While `rst_req_o` is high, all writes are ignored. A key pair written during that time neither arms the watchdog nor leaves a pending first byte.
- R10: When `sync_clr` is 1 at a clock edge, that edge clears `armed_o`, the counter, the pending first byte and `rst_req_o`.
- R11: Pulling `rst_n` low clears `armed_o` and `rst_req_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of all watchdog state |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 8 | Write data |
| rst_req_o | output | 1 | Reset request, high for 98 cycles after expiry |
| armed_o | output | 1 | Watchdog armed status |

## Verification
A first key byte that is pending when it should not be shows up only when a following 8'hE1 write arms the watchdog unexpectedly, or fails to arm it. For this reason the bench predicts `armed_o` after every write of a random mix. A counter that is cleared wrongly or steps wrongly moves the rising edge of `rst_req_o` by whole cycles, and that edge is timed to the exact clock, both after arming and after a restart. A pulse counter that is off by one changes the measured 98-cycle width.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef logic [7:0] wbyte_t;

  localparam int unsigned DEF_CNT_W     = 14;
  localparam int unsigned DEF_ADDR_W    = 4;
  localparam int unsigned DEF_PULSE_LEN = 98;
  localparam wbyte_t      DEF_KEY_FIRST = 8'h1E;
  localparam wbyte_t      DEF_KEY_NEXT  = 8'hE1;
endpackage

// File: rtl/wdog_keytrack.sv
module wdog_keytrack
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W       = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = ADDR_W'(6),
  parameter wbyte_t      KEY_FIRST    = DEF_KEY_FIRST,
  parameter wbyte_t      KEY_NEXT     = DEF_KEY_NEXT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              block,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  wbyte_t            wr_data,
  output logic              key_hit
);
  logic pend_q, pend_d;
  logic wr_ok;

  assign wr_ok = wr_en && (wr_addr == RESTART_ADDR) && !block;

  always_comb begin
    pend_d  = pend_q;
    key_hit = 1'b0;
    if (clr || block) begin
      pend_d = 1'b0;
    end else if (wr_ok) begin
      if (pend_q && (wr_data == KEY_NEXT)) begin
        key_hit = 1'b1;
        pend_d  = 1'b0;
      end else if (!pend_q && (wr_data == KEY_FIRST)) begin
        pend_d = 1'b1;
      end else begin
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R3: a pending first byte never survives a restart write of another value
  assert_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && wr_ok && (wr_data != KEY_NEXT)) |=> !pend_q);

  // R9: nothing stays pending while the reset request is active
  assert_block_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    block |=> !pend_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic key_hit,
  output logic armed,
  output logic expire
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = armed_q && !key_hit;
  assign expire = cnt_en && (cnt_q == CNT_MAX) && !clr;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (clr || expire) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (key_hit) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (cnt_en) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed = armed_q;

  // R6: the count stays at zero whenever the watchdog is disarmed
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (cnt_q == '0));

  // R7: a restart always leaves the counter at zero
  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && !clr) |=> (cnt_q == '0) && armed_q);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
#(
  parameter int unsigned PULSE_LEN = DEF_PULSE_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fire,
  output logic active
);
  localparam int unsigned PCNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [PCNT_W-1:0] PCNT_TOP = PCNT_W'(PULSE_LEN - 1);

  logic              act_q, act_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;

  always_comb begin
    act_d  = act_q;
    pcnt_d = pcnt_q;
    if (clr) begin
      act_d  = 1'b0;
      pcnt_d = '0;
    end else if (fire) begin
      act_d  = 1'b1;
      pcnt_d = PCNT_TOP;
    end else if (act_q) begin
      if (pcnt_q == '0) act_d = 1'b0;
      else              pcnt_d = pcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      act_q  <= act_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign active = act_q;

  // R8: the request only ends once the remaining length has run out, or on a clear
  assert_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(pcnt_q) == '0) || $past(clr));
endmodule

// File: rtl/wdog_once.sv
module wdog_once
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W        = DEF_CNT_W,
  parameter int unsigned ADDR_W       = DEF_ADDR_W,
  parameter int unsigned PULSE_LEN    = DEF_PULSE_LEN,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = ADDR_W'(6),
  parameter wbyte_t      KEY_FIRST    = DEF_KEY_FIRST,
  parameter wbyte_t      KEY_NEXT     = DEF_KEY_NEXT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              rst_req_o,
  output logic              armed_o
);
  logic key_hit;
  logic expire;
  logic armed;
  logic req_active;

  wdog_keytrack #(
    .ADDR_W(ADDR_W), .RESTART_ADDR(RESTART_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_NEXT(KEY_NEXT)
  ) u_keys (
    .clk(clk), .rst_n(rst_n), .clr(sync_clr), .block(req_active),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .key_hit(key_hit)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(sync_clr), .key_hit(key_hit),
    .armed(armed), .expire(expire)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .clr(sync_clr), .fire(expire),
    .active(req_active)
  );

  assign rst_req_o = req_active;
  assign armed_o   = armed;

  // R2: arming follows a write of the second key byte to the restart register
  assert_arm_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_en && (wr_addr == RESTART_ADDR) && (wr_data == KEY_NEXT)));

  // R5: disarming only by clear or expiry
  assert_no_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> ($past(sync_clr) || $past(expire)));

  // R8: the request starts only from an expiry
  assert_req_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_active) |-> $past(expire));

  // R9: never armed while the request is active
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && req_active));

  // R10: a synchronous clear leaves everything idle
  assert_sync_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> !armed && !req_active);
endmodule

// File: tb/sim_wdog_once.sv
`timescale 1ns/1ps
module sim_wdog_once;
  localparam logic [3:0] RA = 4'h6;
  localparam int unsigned PERIOD_TICKS = 16384;
  localparam int unsigned PULSE = 98;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_clr = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic       rst_req_o;
  logic       armed_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  wdog_once u0 (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rst_req_o(rst_req_o), .armed_o(armed_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Called at the negedge right after the arming/restart edge.
  // Returns the number of edges until rst_req_o rises.
  task automatic time_to_req(output int n);
    n = 0;
    while (!rst_req_o && n < PERIOD_TICKS + 10) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_width(output int n);
    n = 0;
    while (rst_req_o && n < PULSE + 10) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Key-tracker model: returns next pending state, sets arm on a full pair
  function automatic bit model_step(input bit pend, input logic [3:0] a,
                                    input logic [7:0] d, output bit arm);
    arm = 1'b0;
    if (a != RA) return pend;
    if (pend && d == 8'hE1) begin arm = 1'b1; return 1'b0; end
    if (!pend && d == 8'h1E) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    int n;
    bit pend, arm_m, hit;
    process::self().srandom(32'd7177);

    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 armed after reset", armed_o, 0);
    check("R1 rst_req after reset", rst_req_o, 0);
    wr(RA, 8'hE1);
    check("R1 no pending byte after reset", armed_o, 0);

    // R3: wrong orderings
    wr(RA, 8'hE1); wr(RA, 8'h1E); wr(RA, 8'h55); wr(RA, 8'hE1);
    check("R3 other value cancels", armed_o, 0);
    wr(RA, 8'h1E); wr(RA, 8'h1E); wr(RA, 8'hE1);
    check("R3 repeated first byte cancels", armed_o, 0);

    // R4: other addresses
    wr(4'h3, 8'h1E); wr(4'h3, 8'hE1);
    check("R4 keys at other address ignored", armed_o, 0);
    wr(RA, 8'h1E); wr(4'h2, 8'h00); wr(4'h9, 8'h1E); wr(RA, 8'hE1);
    check("R4 other-address writes keep pending", armed_o, 1);

    // R11: async reset clears immediately
    #2 rst_n = 1'b0;
    #1 check("R11 armed cleared asynchronously", armed_o, 0);
    check("R11 rst_req cleared asynchronously", rst_req_o, 0);
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 + R6: arm then time the expiry
    wr(RA, 8'h1E); wr(RA, 8'hE1);
    check("R2 armed after key pair", armed_o, 1);
    // R5: attempts to disarm
    wr(RA, 8'h00); wr(4'h0, 8'hFF); wr(RA, 8'h1E); wr(RA, 8'h1E);
    check("R5 still armed after writes", armed_o, 1);
    do_reset();
    wr(RA, 8'h1E); wr(RA, 8'hE1);
    time_to_req(n);
    check("R6 edges from arming to request", n, PERIOD_TICKS);
    check("R8 armed dropped at expiry", armed_o, 0);
    // R9: writes during the pulse
    wr(RA, 8'h1E); wr(RA, 8'hE1); wr(RA, 8'h1E);
    check("R9 not armed during request", armed_o, 0);
    pulse_width(n);
    check("R8 request width", n + 6, PULSE);
    check("R8 armed stays low after request", armed_o, 0);
    wr(RA, 8'hE1);
    check("R9 no pending byte survives request", armed_o, 0);

    // R7: restart postpones expiry
    do_reset();
    wr(RA, 8'h1E); wr(RA, 8'hE1);
    idle(10000);
    check("R7 no request before restart", rst_req_o, 0);
    wr(RA, 8'h1E); wr(RA, 8'hE1);
    time_to_req(n);
    check("R7 edges from restart to request", n, PERIOD_TICKS);
    pulse_width(n);
    check("R8 request width second", n, PULSE);

    // R10: sync clear
    do_reset();
    wr(RA, 8'h1E); wr(RA, 8'hE1);
    @(negedge clk); sync_clr = 1'b1; @(negedge clk); sync_clr = 1'b0;
    check("R10 sync clear disarms", armed_o, 0);
    wr(RA, 8'h1E);
    @(negedge clk); sync_clr = 1'b1; @(negedge clk); sync_clr = 1'b0;
    wr(RA, 8'hE1);
    check("R10 sync clear drops pending", armed_o, 0);
    wr(RA, 8'h1E); wr(RA, 8'hE1);
    time_to_req(n);
    check("R10 request reached", rst_req_o, 1);
    idle(5);
    sync_clr = 1'b1; @(negedge clk); sync_clr = 1'b0;
    check("R10 sync clear ends request", rst_req_o, 0);

    // Random mix against the model (R2 R3 R4 R5)
    do_reset();
    pend = 1'b0; arm_m = 1'b0;
    for (int k = 0; k < 400; k++) begin
      logic [3:0] a;
      logic [7:0] d;
      int sel;
      a = ($urandom_range(0, 2) != 0) ? RA : 4'($urandom_range(0, 15));
      sel = $urandom_range(0, 3);
      d = (sel == 0) ? 8'h1E : (sel == 1) ? 8'hE1 : 8'($urandom);
      pend = model_step(pend, a, d, hit);
      if (hit) arm_m = 1'b1;
      wr(a, d);
      if (armed_o !== arm_m) check("R3 random armed state", armed_o, arm_m);
      if (rst_req_o !== 1'b0) check("R6 random no early request", rst_req_o, 0);
    end
    check("R2 random final armed state", armed_o, arm_m);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule